// File: doc/BRIEF.md
# LPC Memory Write Target Controller

This block is the target side of a Low Pin Count bus for memory write cycles only. On every rising clock edge it samples the active-low frame strobe and the 4-bit multiplexed address/data lines. When a write cycle starts, it collects the following in order: the cycle-type nibble, a 32-bit address sent most significant nibble first, and a data byte sent least significant nibble first. It then waits through the host's turnaround, drives a ready sync code, drives one turnaround of all ones, and releases the lines.

The controller offers the captured cycle to a back-end memory model on three outputs: the address, the data byte and an array-versus-register select taken from an address bit. It marks the cycle with a one-clock write strobe. It answers only when the cycle type and the address qualifier bits are valid; any other cycle passes by without the target ever enabling its drivers. A low frame strobe in the middle of a cycle abandons that cycle, and the lines are then judged as a possible new start.

Top module: `lpc_wr_target`

## Requirements
- R1: When `rstN` or `initN` is low at a rising edge, the controller returns to idle and any cycle in progress is dropped. After that edge `ladOe` and `wrStrobe` are 0 and stay 0 until a new cycle is accepted.
- R2: A cycle starts only at a rising edge where `frameN` is 0 and `ladIn` is 4'b0000. With `frameN` low and any other nibble, nothing happens.
- R3: The nibble after the start must have bits [3:2] = 2'b01 and bit [1] = 1 (write). Bit [0] is ignored. With any other value the cycle is ignored.
- R4: The next 8 nibbles form the address, most significant nibble first. `wrAddr` equals that address while `wrStrobe` is high.
- R5: If any of address bits [31:26] is 0, the cycle is ignored. `ladOe` stays 0 and `wrStrobe` stays 0.
- R6: `wrArray` equals address bit 22 (1 = memory array, 0 = register space) while `wrStrobe` is high.
- R7: The next 2 nibbles form the data byte, low nibble first. `wrData` equals that byte while `wrStrobe` is high.
- R8: Count the start edge as clock 1. For an accepted cycle, `ladOe` is 0 through clock 14. During clock 15 the outputs are `ladOe`=1 and `ladOut`=4'b0000 (sync). During clock 16 they are `ladOe`=1 and `ladOut`=4'b1111. From clock 17 on, `ladOe` is 0 again.
- R9: `wrStrobe` is high for exactly one clock, during the sync clock, and only for accepted cycles.
- R10: If `frameN` is low at any edge in the middle of a cycle, that cycle is abandoned and the edge is judged as a start under R2.
- R11: A new cycle may start on the clock right after the release clock (clock 18), and it is handled in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| initN | input | 1 | Synchronous init, active low, same effect as reset |
| frameN | input | 1 | Frame strobe from the host, active low |
| ladIn | input | 4 | Sampled multiplexed address/data lines |
| ladOut | output | 4 | Value the target drives onto the lines |
| ladOe | output | 1 | Output enable for `ladOut` |
| wrAddr | output | 32 | Captured write address |
| wrData | output | 8 | Captured write data |
| wrArray | output | 1 | 1 = array access, 0 = register access |
| wrStrobe | output | 1 | One-clock write pulse to the back end |

## Verification
The hardest cases to create from the ports are those where the controller must drop a cycle it has already partly decoded. This happens when the frame strobe falls again partway through the address, or when reset or init arrives a few clocks before the sync clock. In both cases the output would otherwise have been driven. The bench reaches these cases by driving the prefix of a valid write and then either restarting with a full new write or pulsing reset. It then watches the driver enable and the strobe through the clocks where a completed cycle would have answered. Rejected cycles are built by changing one qualifier at a time, so that every other nibble still forms a valid write.

// File: rtl/lpcw_pkg.sv
package lpcw_pkg;

  localparam int NIB_W = 4;
  localparam int CNT_W = 4;

  localparam logic [NIB_W-1:0] START_CODE = 4'b0000;
  localparam logic [NIB_W-1:0] SYNC_CODE  = 4'b0000;
  localparam logic [NIB_W-1:0] TURN_CODE  = 4'b1111;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_DATA,
    ST_TAR_HOST,
    ST_TAR_GRAB,
    ST_SYNC,
    ST_TAR_DRV,
    ST_RELEASE
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             shiftAddr;
    logic             loadData;
    logic [CNT_W-1:0] nibIdx;
    logic             drive;
    logic             syncCode;
    logic             wrPulse;
  } lpcwStrobes_t;

endpackage

// File: rtl/lpcw_ctrl.sv
module lpcw_ctrl
  import lpcw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frameN,
  input  logic [NIB_W-1:0]   ladIn,
  input  logic               qualOk,
  output lpcwStrobes_t       strobes
);

  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int DATA_NIBS = DATA_W / NIB_W;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

  phase_t           state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             typeOk;

  assign typeOk = (ladIn[3:2] == 2'b01) && ladIn[1];

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    unique case (state)
      ST_IDLE: stateNxt = ST_IDLE;
      ST_CTYPE: begin
        cntNxt   = '0;
        stateNxt = typeOk ? ST_ADDR : ST_IDLE;
      end
      ST_ADDR: begin
        if (cnt == ADDR_LAST) begin
          cntNxt   = '0;
          stateNxt = qualOk ? ST_DATA : ST_IDLE;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_DATA: begin
        if (cnt == DATA_LAST) begin
          cntNxt   = '0;
          stateNxt = ST_TAR_HOST;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_TAR_HOST: stateNxt = ST_TAR_GRAB;
      ST_TAR_GRAB: stateNxt = ST_SYNC;
      ST_SYNC:     stateNxt = ST_TAR_DRV;
      ST_TAR_DRV:  stateNxt = ST_RELEASE;
      ST_RELEASE:  stateNxt = ST_IDLE;
      default:     stateNxt = ST_IDLE;
    endcase
    // a low frame strobe always re-evaluates the lines as a start
    if (!frameN) begin
      cntNxt   = '0;
      stateNxt = (ladIn == START_CODE) ? ST_CTYPE : ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    strobes.shiftAddr = (state == ST_ADDR);
    strobes.loadData  = (state == ST_DATA);
    strobes.nibIdx    = cnt;
    strobes.drive     = (state == ST_SYNC) || (state == ST_TAR_DRV);
    strobes.syncCode  = (state == ST_SYNC);
    strobes.wrPulse   = (state == ST_SYNC);
  end

endmodule

// File: rtl/lpcw_dpath.sv
module lpcw_dpath
  import lpcw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 8,
  parameter int QUAL_LSB = 26,
  parameter int SEL_BIT  = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NIB_W-1:0]   ladIn,
  input  lpcwStrobes_t       strobes,
  output logic               qualOk,
  output logic [NIB_W-1:0]   ladOut,
  output logic               ladOe,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [DATA_W-1:0]  wrData,
  output logic               wrArray,
  output logic               wrStrobe
);

  localparam int DATA_NIBS = DATA_W / NIB_W;

  logic [ADDR_W-1:0] addrSh;
  logic [ADDR_W-1:0] addrNext;
  logic [DATA_W-1:0] dataReg;

  // address as it stands once the current nibble is shifted in
  assign addrNext = {addrSh[ADDR_W-NIB_W-1:0], ladIn};
  assign qualOk   = &addrNext[ADDR_W-1:QUAL_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      addrSh <= '0;
    end else if (strobes.shiftAddr) begin
      addrSh <= addrNext;
    end
  end

  // data arrives low nibble first; the nibble index picks the slot
  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_dataNib
    always_ff @(posedge clk) begin
      if (rst) begin
        dataReg[g*NIB_W +: NIB_W] <= '0;
      end else if (strobes.loadData && (strobes.nibIdx == CNT_W'(g))) begin
        dataReg[g*NIB_W +: NIB_W] <= ladIn;
      end
    end
  end

  assign ladOut   = strobes.syncCode ? SYNC_CODE : TURN_CODE;
  assign ladOe    = strobes.drive;
  assign wrAddr   = addrSh;
  assign wrData   = dataReg;
  assign wrArray  = addrSh[SEL_BIT];
  assign wrStrobe = strobes.wrPulse;

endmodule

// File: rtl/lpc_wr_target.sv
module lpc_wr_target
  import lpcw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 8,
  parameter int QUAL_LSB = 26,
  parameter int SEL_BIT  = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initN,
  input  logic              frameN,
  input  logic [3:0]        ladIn,
  output logic [3:0]        ladOut,
  output logic              ladOe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrArray,
  output logic              wrStrobe
);

  logic         rst;
  logic         qualOk;
  lpcwStrobes_t strobes;

  assign rst = !rstN || !initN;

  lpcw_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .frameN  (frameN),
    .ladIn   (ladIn),
    .qualOk  (qualOk),
    .strobes (strobes)
  );

  lpcw_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .QUAL_LSB (QUAL_LSB),
    .SEL_BIT  (SEL_BIT)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .ladIn    (ladIn),
    .strobes  (strobes),
    .qualOk   (qualOk),
    .ladOut   (ladOut),
    .ladOe    (ladOe),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrArray  (wrArray),
    .wrStrobe (wrStrobe)
  );

endmodule

// File: rtl/lpcw_chk.sv
module lpcw_chk #(
  parameter int ADDR_W   = 32,
  parameter int QUAL_LSB = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              initN,
  input logic              frameN,
  input logic [3:0]        ladOut,
  input logic              ladOe,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrStrobe
);

  // R1: a reset or init edge leaves the target quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    (!rstN || !initN) |=> (!ladOe && !wrStrobe));

  // R5: only qualified addresses reach the back end
  p_addr_qual_r5: assert property (@(posedge clk) disable iff (!rstN || !initN)
    wrStrobe |-> (&wrAddr[ADDR_W-1:QUAL_LSB]));

  // R9: the strobe lasts one clock
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rstN || !initN)
    wrStrobe |=> !wrStrobe);

  // R9: the strobe coincides with the driven sync code
  p_strobe_in_sync_r9: assert property (@(posedge clk) disable iff (!rstN || !initN)
    wrStrobe |-> (ladOe && ladOut == 4'b0000));

  // R8: sync is followed by a driven all-ones turnaround
  p_sync_then_turn_r8: assert property (@(posedge clk) disable iff (!rstN || !initN)
    (ladOe && ladOut == 4'b0000 && frameN) |=> (ladOe && ladOut == 4'b1111));

  // R8: after the driven turnaround the lines are released
  p_release_r8: assert property (@(posedge clk) disable iff (!rstN || !initN)
    (ladOe && ladOut == 4'b1111) |=> !ladOe);

  // R4: address holds steady into the strobe clock
  p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rstN || !initN)
    wrStrobe |-> $stable(wrAddr));

endmodule

bind lpc_wr_target lpcw_chk #(
  .ADDR_W   (ADDR_W),
  .QUAL_LSB (QUAL_LSB)
) u_lpcw_chk (
  .clk      (clk),
  .rstN     (rstN),
  .initN    (initN),
  .frameN   (frameN),
  .ladOut   (ladOut),
  .ladOe    (ladOe),
  .wrAddr   (wrAddr),
  .wrStrobe (wrStrobe)
);

// File: tb/test_lpc_wr_target.sv
module test_lpc_wr_target;

  logic        clk = 1'b0;
  logic        rstN, initN, frameN;
  logic [3:0]  ladIn;
  logic [3:0]  ladOut;
  logic        ladOe;
  logic [31:0] wrAddr;
  logic [7:0]  wrData;
  logic        wrArray;
  logic        wrStrobe;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  lpc_wr_target i_lpc_wr_target (
    .clk      (clk),
    .rstN     (rstN),
    .initN    (initN),
    .frameN   (frameN),
    .ladIn    (ladIn),
    .ladOut   (ladOut),
    .ladOe    (ladOe),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrArray  (wrArray),
    .wrStrobe (wrStrobe)
  );

  // {cycle type, address, data, accepted}
  localparam logic [44:0] VEC [8] = '{
    {4'h6, 32'hFFC0_1234, 8'hA5, 1'b1},
    {4'h7, 32'hFF80_0055, 8'h3C, 1'b1},
    {4'h4, 32'hFFFF_FFFF, 8'h11, 1'b0},
    {4'h2, 32'hFFFF_FFFF, 8'h22, 1'b0},
    {4'h6, 32'h7FC0_0000, 8'h33, 1'b0},
    {4'h6, 32'hFBFF_FFFF, 8'h44, 1'b0},
    {4'h6, 32'hFC00_0000, 8'h00, 1'b1},
    {4'h6, 32'hFFFF_FFFF, 8'hFF, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] hostNib(input int k, input logic [3:0] startNib,
                                         input logic [3:0] ctype, input logic [31:0] addr,
                                         input logic [7:0] data);
    if (k == 1) return startNib;
    if (k == 2) return ctype;
    if (k >= 3 && k <= 10) return addr[31 - 4*(k-3) -: 4];
    if (k == 11) return data[3:0];
    if (k == 12) return data[7:4];
    return 4'hF;
  endfunction

  // one 17-clock write; sample 1 ns after each edge, then drive the next clock
  task automatic runWrite(input logic [3:0] startNib, input logic [3:0] ctype,
                          input logic [31:0] addr, input logic [7:0] data,
                          input logic accept, input string name);
    for (int k = 1; k <= 17; k++) begin
      frameN = (k == 1) ? 1'b0 : 1'b1;
      ladIn  = hostNib(k, startNib, ctype, addr, data);
      @(posedge clk);
      #1;
      // outputs now show clock k+1
      begin
        logic expOe, expStb;
        expOe  = accept && (k == 14 || k == 15);
        expStb = accept && (k == 14);
        check(ladOe == expOe, $sformatf("R8 %s oe clk%0d", name, k+1), 32'(ladOe), 32'(expOe));
        check(wrStrobe == expStb, $sformatf("R9 %s strobe clk%0d", name, k+1),
              32'(wrStrobe), 32'(expStb));
        if (expOe) begin
          logic [3:0] expOut;
          expOut = (k == 14) ? 4'h0 : 4'hF;
          check(ladOut == expOut, $sformatf("R8 %s lad clk%0d", name, k+1),
                32'(ladOut), 32'(expOut));
        end
        if (expStb) begin
          check(wrAddr == addr, $sformatf("R4 %s addr", name), wrAddr, addr);
          check(wrData == data, $sformatf("R7 %s data", name), 32'(wrData), 32'(data));
          check(wrArray == addr[22], $sformatf("R6 %s array", name),
                32'(wrArray), 32'(addr[22]));
        end
      end
    end
  endtask

  // valid write prefix of n clocks, target must stay quiet
  task automatic runPrefix(input int n, input string name);
    for (int k = 1; k <= n; k++) begin
      frameN = (k == 1) ? 1'b0 : 1'b1;
      ladIn  = hostNib(k, 4'h0, 4'h6, 32'hFFC0_ABCD, 8'h5A);
      @(posedge clk);
      #1;
      check(!ladOe && !wrStrobe, $sformatf("R10 %s quiet clk%0d", name, k+1),
            32'({ladOe, wrStrobe}), 32'h0);
    end
  endtask

  // valid write with reset or init pulsed at clock 9
  task automatic runAbort(input bit useInit, input string name);
    for (int k = 1; k <= 17; k++) begin
      frameN = (k == 1) ? 1'b0 : 1'b1;
      ladIn  = hostNib(k, 4'h0, 4'h6, 32'hFFC0_0F0F, 8'h77);
      if (k == 9) begin
        if (useInit) initN = 1'b0;
        else         rstN  = 1'b0;
      end else begin
        initN = 1'b1;
        rstN  = 1'b1;
      end
      @(posedge clk);
      #1;
      check(!ladOe && !wrStrobe, $sformatf("R1 %s quiet clk%0d", name, k+1),
            32'({ladOe, wrStrobe}), 32'h0);
    end
  endtask

  initial begin
    rstN   = 1'b0;
    initN  = 1'b1;
    frameN = 1'b1;
    ladIn  = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    check(!ladOe && !wrStrobe, "R1 reset state", 32'({ladOe, wrStrobe}), 32'h0);
    rstN = 1'b1;
    @(posedge clk);
    #1;

    // table walk; consecutive entries also start at clock 18 (R11)
    for (int i = 0; i < 8; i++) begin
      runWrite(4'h0, VEC[i][44:41], VEC[i][40:9], VEC[i][8:1], VEC[i][0],
               $sformatf("R3/R5/R11 vec%0d", i));
    end

    // R2: frame low with a non-zero nibble starts nothing
    runWrite(4'h5, 4'h6, 32'hFFC0_0001, 8'h12, 1'b0, "R2 bad start");
    runWrite(4'h0, 4'h6, 32'hFFC0_0002, 8'h34, 1'b1, "R2 good start");

    // R10: frame drops mid-address, then a full write follows
    runPrefix(6, "R10 prefix");
    runWrite(4'h0, 4'h6, 32'hFF80_BEEF, 8'hC3, 1'b1, "R10 restart");
    // R10: frame drops during turnaround before sync
    runPrefix(13, "R10 late prefix");
    runWrite(4'h0, 4'h7, 32'hFFC0_0100, 8'h96, 1'b1, "R10 late restart");

    // R1: reset and init abort a cycle in progress
    runAbort(1'b1, "R1 init abort");
    runAbort(1'b0, "R1 reset abort");
    runWrite(4'h0, 4'h6, 32'hFC40_0000, 8'h81, 1'b1, "R1 after abort");

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule